// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps the three stack pointer banks of a processor core: user, master and interrupt. It also owns the live address register A7, which is the stack pointer seen by instructions. Which bank stands behind A7 is chosen by the supervisor and master bits of the status register. Whenever a status register update changes that choice, the unit parks the current A7 value in the bank that was in use and fetches the newly selected bank into A7.

The unit also executes the privileged move between a general register and a control register. That operation covers the three stack pointers, the vector base register and the cache control register. The decoder hands over a request with its direction bit, the 16-bit extension word and the operand value. On a read, the unit returns the control register value one cycle later, tagged with the general register it targets. When that target is A7, the unit writes A7 itself. The general register write-back path also feeds the unit, so writes to A7 land in the live copy.

Top module: `sp_bank_unit`

## Requirements
- R1: After reset the status register reads 0x2700, A7, all three banks, the vector base and the cache control register read zero, and the interrupt bank is active.
- R2: Bank selection uses status register bit 13 (S) and bit 12 (M): S=0 selects user (index 1), S=1 with M=1 selects master (index 0), and S=1 with M=0 selects interrupt (index 2).
- R3: When a status register write changes the selected bank, the cycle-end A7 value is saved into the old bank and A7 is loaded from the new bank on the same clock edge.
- R4: Control register numbers are 0x800 user SP, 0x803 master SP, 0x804 interrupt SP, 0x801 vector base and 0x002 cache control. A read presents the value on cr_rd_data_o with cr_rd_valid_o high in the cycle after the request.
- R5: In the extension word, bit 15 selects an address (1) or a data (0) register, bits 14:12 give its number and bits 11:0 give the control register number. cr_rd_reg_o returns bits 15:12. cr_dir_i=1 moves the general register into the control register and cr_dir_i=0 moves the other way.
- R6: A read of the active bank returns live A7. A write to the active bank sets A7 at the next edge. A write to an inactive bank leaves A7 unchanged.
- R7: A write to cache control stores the value and leaves A7 and the bank selection unchanged.
- R8: A request made while S=0 transfers nothing, gives no read response and pulses priv_viol_o in the next cycle.
- R9: An unimplemented control register number pulses illegal_cr_o in the next cycle and changes no state. A read of such a number returns zero with cr_rd_valid_o high.
- R10: A read whose target is A7 (bits 15:12 = 0xF) writes A7. If a status register update switches the bank in the same cycle, the written value goes to the old bank before the new bank is loaded. A write to the active bank that coincides with a switch is handled the same way.
- R11: A general register write-back to A7 (address 0xF) updates live A7. A same-cycle control register read targeting A7 takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_we_i | input | 1 | Status register write strobe |
| sr_wdata_i | input | 16 | New status register value |
| gpr_we_i | input | 1 | General register write-back strobe |
| gpr_waddr_i | input | 4 | Write-back register, bit 3 = address register |
| gpr_wdata_i | input | 32 | Write-back value |
| cr_req_i | input | 1 | Control register move request |
| cr_dir_i | input | 1 | 1 = general to control, 0 = control to general |
| cr_ext_i | input | 16 | Extension word |
| cr_gpr_val_i | input | 32 | Operand value for moves into a control register |
| cr_rd_valid_o | output | 1 | Read result valid |
| cr_rd_data_o | output | 32 | Read result |
| cr_rd_reg_o | output | 4 | Target general register of the read |
| priv_viol_o | output | 1 | Privilege violation pulse |
| illegal_cr_o | output | 1 | Unimplemented control register pulse |
| sr_o | output | 16 | Status register |
| a7_o | output | 32 | Live A7 |
| vbr_o | output | 32 | Vector base register |
| cacr_o | output | 32 | Cache control register |

## Verification
The bench writes distinct values into each bank and walks the status register through all three modes. It then reads the banks back to confirm that each switch saved the outgoing A7. A unit that skipped the save would return a stale bank value, and one that swapped the index mapping would load the wrong pointer. A read of the active bank is checked against a fresh A7 write-back, which exposes a design that returns the stale bank copy. The worst corner is a write to A7 or to the active bank in the same cycle as a mode switch: a wrong ordering would either lose the value or leave it in A7 under the new mode. Supervisor-only access and unimplemented numbers are checked for silence on every register they could corrupt.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic [1:0] {
    BANK_MSP = 2'd0,
    BANK_USP = 2'd1,
    BANK_ISP = 2'd2
  } bank_e;

  typedef enum logic [2:0] {
    CR_NONE,
    CR_USP,
    CR_MSP,
    CR_ISP,
    CR_VBR,
    CR_CACR
  } cr_e;

  localparam int          NBANK    = 3;
  localparam int          SR_W     = 16;
  localparam int          SR_S_BIT = 13;
  localparam int          SR_M_BIT = 12;
  localparam logic [15:0] SR_RST   = 16'h2700;

  localparam logic [11:0] CRN_USP  = 12'h800;
  localparam logic [11:0] CRN_VBR  = 12'h801;
  localparam logic [11:0] CRN_MSP  = 12'h803;
  localparam logic [11:0] CRN_ISP  = 12'h804;
  localparam logic [11:0] CRN_CACR = 12'h002;

  localparam logic [3:0]  GPR_A7   = 4'hF;

  function automatic bank_e pick_bank(logic s, logic m);
    if (!s)     return BANK_USP;
    else if (m) return BANK_MSP;
    else        return BANK_ISP;
  endfunction
endpackage

// File: rtl/spb_crdec.sv
module spb_crdec
  import spb_pkg::*;
(
  input  logic [15:0] ext_i,
  output cr_e         kind_o,
  output logic        is_sp_o,
  output bank_e       sp_idx_o,
  output logic [3:0]  gpr_o
);
  assign gpr_o = ext_i[15:12];

  always_comb begin
    kind_o   = CR_NONE;
    sp_idx_o = BANK_USP;
    unique case (ext_i[11:0])
      CRN_USP:  begin kind_o = CR_USP; sp_idx_o = BANK_USP; end
      CRN_MSP:  begin kind_o = CR_MSP; sp_idx_o = BANK_MSP; end
      CRN_ISP:  begin kind_o = CR_ISP; sp_idx_o = BANK_ISP; end
      CRN_VBR:  kind_o = CR_VBR;
      CRN_CACR: kind_o = CR_CACR;
      default:  kind_o = CR_NONE;
    endcase
  end

  assign is_sp_o = (kind_o == CR_USP) || (kind_o == CR_MSP) || (kind_o == CR_ISP);
endmodule

// File: rtl/spb_bank_file.sv
module spb_bank_file
  import spb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bank_e         new_sel_i,
  input  logic          live_we_i,
  input  logic [DW-1:0] live_wd_i,
  input  logic          bk_we_i,
  input  bank_e         bk_idx_i,
  input  logic [DW-1:0] bk_wd_i,
  input  bank_e         rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] a7_o,
  output bank_e         act_o
);
  logic [DW-1:0] bank_q [NBANK];
  logic [DW-1:0] a7_q;
  bank_e         act_q;
  logic [DW-1:0] a7_eff;
  logic          switching;

  // live copy after this cycle's writes, before any switch
  always_comb begin
    a7_eff = a7_q;
    if (live_we_i)                       a7_eff = live_wd_i;
    if (bk_we_i && (bk_idx_i == act_q))  a7_eff = bk_wd_i;
  end

  assign switching = (new_sel_i != act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBANK; i++) bank_q[i] <= '0;
      a7_q  <= '0;
      act_q <= BANK_ISP;
    end else begin
      for (int i = 0; i < NBANK; i++) begin
        if (switching && (act_q == bank_e'(i)))
          bank_q[i] <= a7_eff;
        else if (bk_we_i && (bk_idx_i == bank_e'(i)) && (bk_idx_i != act_q))
          bank_q[i] <= bk_wd_i;
      end
      if (!switching)
        a7_q <= a7_eff;
      else if (bk_we_i && (bk_idx_i == new_sel_i))
        a7_q <= bk_wd_i;
      else
        a7_q <= bank_q[new_sel_i];
      act_q <= new_sel_i;
    end
  end

  assign rd_data_o = (rd_idx_i == act_q) ? a7_q : bank_q[rd_idx_i];
  assign a7_o      = a7_q;
  assign act_o     = act_q;

  // R3
  save_on_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> (bank_q[$past(act_q)] == $past(a7_eff)));

  // R3
  load_on_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_q != $past(act_q)) && !$past(bk_we_i)) |-> (a7_q == $past(bank_q[new_sel_i])));
endmodule

// File: rtl/sp_bank_unit.sv
module sp_bank_unit
  import spb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sr_we_i,
  input  logic [15:0]   sr_wdata_i,
  input  logic          gpr_we_i,
  input  logic [3:0]    gpr_waddr_i,
  input  logic [DW-1:0] gpr_wdata_i,
  input  logic          cr_req_i,
  input  logic          cr_dir_i,
  input  logic [15:0]   cr_ext_i,
  input  logic [DW-1:0] cr_gpr_val_i,
  output logic          cr_rd_valid_o,
  output logic [DW-1:0] cr_rd_data_o,
  output logic [3:0]    cr_rd_reg_o,
  output logic          priv_viol_o,
  output logic          illegal_cr_o,
  output logic [15:0]   sr_o,
  output logic [DW-1:0] a7_o,
  output logic [DW-1:0] vbr_o,
  output logic [DW-1:0] cacr_o
);
  logic [SR_W-1:0] sr_q, sr_n;
  logic [DW-1:0]   vbr_q, cacr_q;
  logic            rd_valid_q, priv_q, ill_q;
  logic [DW-1:0]   rd_data_q;
  logic [3:0]      rd_reg_q;

  cr_e        kind;
  logic       is_sp;
  bank_e      sp_idx;
  logic [3:0] gpr_sel;

  spb_crdec u_dec (
    .ext_i    (cr_ext_i),
    .kind_o   (kind),
    .is_sp_o  (is_sp),
    .sp_idx_o (sp_idx),
    .gpr_o    (gpr_sel)
  );

  logic    sup, go, go_wr, go_rd, bad;
  logic [DW-1:0] rd_val, sp_rd;
  bank_e   new_sel, act;
  logic    live_we;
  logic [DW-1:0] live_wd;

  assign sup   = sr_q[SR_S_BIT];
  assign go    = cr_req_i && sup && (kind != CR_NONE);
  assign bad   = cr_req_i && sup && (kind == CR_NONE);
  assign go_wr = go && cr_dir_i;
  assign go_rd = cr_req_i && sup && !cr_dir_i;

  assign sr_n    = sr_we_i ? sr_wdata_i : sr_q;
  // selection re-evaluated every cycle, so a cache control write re-checks it too
  assign new_sel = pick_bank(sr_n[SR_S_BIT], sr_n[SR_M_BIT]);

  always_comb begin
    unique case (kind)
      CR_VBR:  rd_val = vbr_q;
      CR_CACR: rd_val = cacr_q;
      CR_NONE: rd_val = '0;
      default: rd_val = sp_rd;
    endcase
  end

  // read into A7 wins over write-back
  always_comb begin
    live_we = 1'b0;
    live_wd = gpr_wdata_i;
    if (go_rd && (gpr_sel == GPR_A7)) begin
      live_we = 1'b1;
      live_wd = rd_val;
    end else if (gpr_we_i && (gpr_waddr_i == GPR_A7)) begin
      live_we = 1'b1;
    end
  end

  spb_bank_file #(.DW(DW)) u_banks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .new_sel_i (new_sel),
    .live_we_i (live_we),
    .live_wd_i (live_wd),
    .bk_we_i   (go_wr && is_sp),
    .bk_idx_i  (sp_idx),
    .bk_wd_i   (cr_gpr_val_i),
    .rd_idx_i  (sp_idx),
    .rd_data_o (sp_rd),
    .a7_o      (a7_o),
    .act_o     (act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= SR_RST;
      vbr_q      <= '0;
      cacr_q     <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      rd_reg_q   <= '0;
      priv_q     <= 1'b0;
      ill_q      <= 1'b0;
    end else begin
      sr_q <= sr_n;
      if (go_wr && (kind == CR_VBR))  vbr_q  <= cr_gpr_val_i;
      if (go_wr && (kind == CR_CACR)) cacr_q <= cr_gpr_val_i;
      rd_valid_q <= go_rd;
      if (go_rd) begin
        rd_data_q <= rd_val;
        rd_reg_q  <= gpr_sel;
      end
      priv_q <= cr_req_i && !sup;
      ill_q  <= bad;
    end
  end

  assign cr_rd_valid_o = rd_valid_q;
  assign cr_rd_data_o  = rd_data_q;
  assign cr_rd_reg_o   = rd_reg_q;
  assign priv_viol_o   = priv_q;
  assign illegal_cr_o  = ill_q;
  assign sr_o          = sr_q;
  assign vbr_o         = vbr_q;
  assign cacr_o        = cacr_q;

  // R2
  bank_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == pick_bank(sr_q[SR_S_BIT], sr_q[SR_M_BIT]));

  // R8
  priv_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_req_i && !sr_q[SR_S_BIT]) |=> (priv_viol_o && !cr_rd_valid_o
      && $stable(vbr_q) && $stable(cacr_q)));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_req_i && sr_q[SR_S_BIT] && (kind == CR_NONE)) |=> (illegal_cr_o
      && $stable(vbr_q) && $stable(cacr_q)));

  // R9
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_req_i && !cr_dir_i && sr_q[SR_S_BIT] && (kind == CR_NONE))
      |=> (cr_rd_valid_o && (cr_rd_data_o == '0)));

  // R7
  cacr_keeps_a7_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr && (kind == CR_CACR) && !sr_we_i && !live_we) |=> $stable(a7_o));
endmodule

// File: tb/tb_sp_bank_unit.sv
module tb_sp_bank_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sr_we = 1'b0;
  logic [15:0] sr_wdata = '0;
  logic        gpr_we = 1'b0;
  logic [3:0]  gpr_waddr = '0;
  logic [31:0] gpr_wdata = '0;
  logic        cr_req = 1'b0;
  logic        cr_dir = 1'b0;
  logic [15:0] cr_ext = '0;
  logic [31:0] cr_val = '0;
  logic        rd_valid, priv_viol, illegal_cr;
  logic [31:0] rd_data, a7, vbr, cacr;
  logic [3:0]  rd_reg;
  logic [15:0] sr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sp_bank_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wdata),
    .gpr_we_i(gpr_we), .gpr_waddr_i(gpr_waddr), .gpr_wdata_i(gpr_wdata),
    .cr_req_i(cr_req), .cr_dir_i(cr_dir), .cr_ext_i(cr_ext), .cr_gpr_val_i(cr_val),
    .cr_rd_valid_o(rd_valid), .cr_rd_data_o(rd_data), .cr_rd_reg_o(rd_reg),
    .priv_viol_o(priv_viol), .illegal_cr_o(illegal_cr),
    .sr_o(sr), .a7_o(a7), .vbr_o(vbr), .cacr_o(cacr)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // one clock edge with the given stimulus, outputs sampled at the next falling edge
  task automatic apply(logic req, logic dir, logic [15:0] ext, logic [31:0] val,
                       logic swe, logic [15:0] sval, logic gwe, logic [31:0] gval);
    cr_req = req; cr_dir = dir; cr_ext = ext; cr_val = val;
    sr_we = swe; sr_wdata = sval;
    gpr_we = gwe; gpr_waddr = 4'hF; gpr_wdata = gval;
    @(negedge clk);
    cr_req = 1'b0; sr_we = 1'b0; gpr_we = 1'b0;
  endtask

  task automatic cr_write(logic [15:0] ext, logic [31:0] val);
    apply(1'b1, 1'b1, ext, val, 1'b0, 16'h0, 1'b0, 32'h0);
  endtask

  task automatic cr_read(logic [15:0] ext);
    apply(1'b1, 1'b0, ext, 32'h0, 1'b0, 16'h0, 1'b0, 32'h0);
  endtask

  task automatic set_sr(logic [15:0] v);
    apply(1'b0, 1'b0, 16'h0, 32'h0, 1'b1, v, 1'b0, 32'h0);
  endtask

  task automatic wb_a7(logic [31:0] v);
    apply(1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 16'h0, 1'b1, v);
  endtask

  task automatic t_reset;
    chk("R1 sr", {16'h0, sr}, 32'h0000_2700);
    chk("R1 a7", a7, 32'h0);
    chk("R1 vbr", vbr, 32'h0);
    chk("R1 cacr", cacr, 32'h0);
    wb_a7(32'hA000_0000);
    chk("R11 a7 writeback", a7, 32'hA000_0000);
    cr_read(16'h0804);
    chk("R1 isp active after reset", rd_data, 32'hA000_0000);
    chk("R6 live read valid", {31'h0, rd_valid}, 32'h1);
    cr_read(16'h0800);
    chk("R1 usp zero", rd_data, 32'h0);
  endtask

  task automatic t_ctrl_regs;
    cr_write(16'h0801, 32'h1234_5600);
    chk("R4 vbr write", vbr, 32'h1234_5600);
    cr_read(16'h3801);
    chk("R4 vbr read", rd_data, 32'h1234_5600);
    chk("R5 rd reg D3", {28'h0, rd_reg}, 32'h3);
    cr_write(16'h0002, 32'h8000_0000);
    chk("R7 cacr write", cacr, 32'h8000_0000);
    chk("R7 a7 untouched", a7, 32'hA000_0000);
    cr_read(16'h0804);
    chk("R7 isp still selected", rd_data, 32'hA000_0000);
  endtask

  task automatic t_switch;
    cr_write(16'h0803, 32'h4000_0000);
    cr_write(16'h0800, 32'h1000_0000);
    chk("R6 inactive write keeps a7", a7, 32'hA000_0000);
    set_sr(16'h3700);
    chk("R2 master active", a7, 32'h4000_0000);
    cr_read(16'hA804);
    chk("R3 isp saved", rd_data, 32'hA000_0000);
    chk("R5 rd reg A2", {28'h0, rd_reg}, 32'hA);
    set_sr(16'h0000);
    chk("R2 user active", a7, 32'h1000_0000);
    cr_write(16'h0801, 32'hDEAD_0000);
    chk("R8 priv flag", {31'h0, priv_viol}, 32'h1);
    chk("R8 vbr kept", vbr, 32'h1234_5600);
    cr_read(16'h0801);
    chk("R8 no read", {31'h0, rd_valid}, 32'h0);
    set_sr(16'h2000);
    chk("R2 interrupt active", a7, 32'hA000_0000);
    cr_read(16'h0800);
    chk("R3 usp saved", rd_data, 32'h1000_0000);
    cr_read(16'h0803);
    chk("R3 msp saved", rd_data, 32'h4000_0000);
  endtask

  task automatic t_active_write;
    cr_write(16'h0804, 32'hB000_0000);
    chk("R6 active write to a7", a7, 32'hB000_0000);
  endtask

  task automatic t_illegal;
    cr_write(16'h0005, 32'h0000_0077);
    chk("R9 illegal flag", {31'h0, illegal_cr}, 32'h1);
    chk("R9 vbr kept", vbr, 32'h1234_5600);
    chk("R9 cacr kept", cacr, 32'h8000_0000);
    chk("R9 a7 kept", a7, 32'hB000_0000);
    cr_read(16'h1805);
    chk("R9 read valid", {31'h0, rd_valid}, 32'h1);
    chk("R9 read zero", rd_data, 32'h0);
  endtask

  task automatic t_a7_dest;
    apply(1'b1, 1'b0, 16'hF801, 32'h0, 1'b1, 16'h3000, 1'b0, 32'h0);
    chk("R10 switch after a7 write", a7, 32'h4000_0000);
    cr_read(16'h0804);
    chk("R10 value parked in isp", rd_data, 32'h1234_5600);
    apply(1'b1, 1'b1, 16'h0803, 32'h4400_0000, 1'b1, 16'h2000, 1'b0, 32'h0);
    chk("R10 isp loaded", a7, 32'h1234_5600);
    cr_read(16'h0803);
    chk("R10 msp got write", rd_data, 32'h4400_0000);
    apply(1'b1, 1'b0, 16'hF002, 32'h0, 1'b0, 16'h0, 1'b1, 32'h0000_0055);
    chk("R11 read beats writeback", a7, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_regs();
    t_switch();
    t_active_write();
    t_illegal();
    t_a7_dest();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule